// File: doc/BRIEF.md
# Loop-free round-robin arbiter

This block shares one resource among four requesters, A to D, so that none of them can starve. Each cycle it takes a request vector and returns a grant that names at most one requester. The grant is combinational from the requests and a stored priority pointer. The pointer names the requester that currently ranks highest. After every grant, the pointer moves to the requester that follows the winner in the cycle A, B, C, D, A.

The priority rotation needs no combinational loop. A fixed-order chain of 2N-1 stages carries the requests in the order A,B,C,D,A,B,C. The pointer switches off the leading copies of the requesters that rank below it. The two grant outputs of each duplicated requester are then ORed into one grant bit. The only feedback path runs through the pointer register.

Top module: `rr_arbiter_loopfree`

## Requirements
- R1: A synchronous active-high reset sets the pointer to A, so the first cycle after reset with all requests active grants A. Bit 0 of `req` and `gnt` is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R2: `gnt` is one-hot or all zeros in every cycle.
- R3: When `req` is all zeros, `gnt` is all zeros.
- R4: `gnt` never has a bit set whose `req` bit is clear.
- R5: When any request is active, the grant goes in the same cycle to the first active requester in the order that starts at the pointer. Pointer A ranks A,B,C,D. Pointer B ranks B,C,D,A. Pointer C ranks C,D,A,B. Pointer D ranks D,A,B,C.
- R6: At the clock edge after a grant to requester i, the pointer becomes i+1, and D wraps to A.
- R7: At a clock edge where no grant is given, the pointer keeps its value.
- R8: A requester that holds its request without a break is granted within N (four) consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the pointer updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N (4) | Request lines, bit 0 = A to bit 3 = D |
| gnt | output | N (4) | Combinational one-hot grant, same bit order as `req` |

## Verification
The bound checker covers the properties that hold in every cycle: the one-hot or zero grant, no grant without a request, no grant when idle, a grant whenever some request is active, and the rule that the requester after the last winner wins next if it requests. It also counts consecutive cycles in which each requester waits, and flags any wait that reaches N. A behavioural model in the bench ranks the requesters from its own pointer and compares the grant in every cycle. Only these scenarios show the exact ranking for each pointer value over every request pattern, the pointer held through idle cycles, the wrap from D to A, and the return to A after a reset in the middle of a run.

// File: rtl/rr_pkg.sv
package rr_pkg;
  parameter int RR_N_DEFAULT = 4;

  // Width of an index into N requesters, at least one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_stage_mask.sv
// Enable for each stage of the unrolled chain. A leading stage s < N-1
// is live only when the pointer does not rank above it.
module rr_stage_mask #(
  parameter int N    = rr_pkg::RR_N_DEFAULT,
  parameter int IDXW = rr_pkg::idx_w(N),
  parameter int S    = 2 * N - 1
) (
  input  logic [IDXW-1:0] ptr,
  output logic [S-1:0]    stage_en
);
  for (genvar s = 0; s < S; s++) begin : g_en
    if (s < N - 1) begin : g_masked
      assign stage_en[s] = (ptr <= IDXW'(s));
    end else begin : g_open
      assign stage_en[s] = 1'b1;
    end
  end
endmodule

// File: rtl/rr_fixed_chain.sv
// Fixed-order priority chain: stage 0 ranks highest.
module rr_fixed_chain #(
  parameter int S = 7
) (
  input  logic [S-1:0] stage_req,
  output logic [S-1:0] stage_gnt
);
  logic [S-1:0] taken;

  assign taken[0] = 1'b0;
  for (genvar s = 0; s < S; s++) begin : g_stage
    assign stage_gnt[s] = stage_req[s] & ~taken[s];
    if (s < S - 1) begin : g_carry
      assign taken[s+1] = taken[s] | stage_req[s];
    end
  end
endmodule

// File: rtl/rr_grant_merge.sv
// Folds the second copy of each duplicated requester back onto its grant bit.
module rr_grant_merge #(
  parameter int N = rr_pkg::RR_N_DEFAULT,
  parameter int S = 2 * N - 1
) (
  input  logic [S-1:0] stage_gnt,
  output logic [N-1:0] gnt
);
  for (genvar i = 0; i < N; i++) begin : g_merge
    if (i < N - 1) begin : g_dual
      assign gnt[i] = stage_gnt[i] | stage_gnt[i+N];
    end else begin : g_single
      assign gnt[i] = stage_gnt[i];
    end
  end
endmodule

// File: rtl/rr_ptr_reg.sv
// Priority pointer: moves to the requester after the winner, holds when idle.
module rr_ptr_reg #(
  parameter int N    = rr_pkg::RR_N_DEFAULT,
  parameter int IDXW = rr_pkg::idx_w(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    gnt,
  output logic [IDXW-1:0] ptr
);
  logic [IDXW-1:0] win_idx;
  logic [IDXW-1:0] ptr_nxt;
  logic            any_gnt;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) win_idx = IDXW'(i);
    end
  end

  assign any_gnt = |gnt;
  assign ptr_nxt = (win_idx == IDXW'(N - 1)) ? '0 : win_idx + IDXW'(1);

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (any_gnt) ptr <= ptr_nxt;
  end
endmodule

// File: rtl/rr_arbiter_loopfree.sv
module rr_arbiter_loopfree #(
  parameter int N = rr_pkg::RR_N_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int IDXW = rr_pkg::idx_w(N);
  localparam int S    = 2 * N - 1;

  logic [IDXW-1:0] ptr;
  logic [S-1:0]    stage_en;
  logic [S-1:0]    stage_req;
  logic [S-1:0]    stage_gnt;

  rr_stage_mask #(.N(N), .IDXW(IDXW), .S(S)) u_mask (
    .ptr      (ptr),
    .stage_en (stage_en)
  );

  // Stage s carries requester s mod N: A,B,C,D,A,B,C for N = 4.
  for (genvar s = 0; s < S; s++) begin : g_fan
    assign stage_req[s] = req[s % N] & stage_en[s];
  end

  rr_fixed_chain #(.S(S)) u_chain (
    .stage_req (stage_req),
    .stage_gnt (stage_gnt)
  );

  rr_grant_merge #(.N(N), .S(S)) u_merge (
    .stage_gnt (stage_gnt),
    .gnt       (gnt)
  );

  rr_ptr_reg #(.N(N), .IDXW(IDXW)) u_ptr (
    .clk (clk),
    .rst (rst),
    .gnt (gnt),
    .ptr (ptr)
  );
endmodule

// File: rtl/rr_arbiter_loopfree_chk.sv
module rr_arbiter_loopfree_chk #(
  parameter int N = rr_pkg::RR_N_DEFAULT
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt
);
  localparam int CW = $clog2(N) + 2;

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt & ~req) == '0);

  assert_idle_no_grant_R3: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (gnt == '0));

  assert_work_conserving_R5: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (gnt != '0));

  for (genvar i = 0; i < N; i++) begin : g_req
    localparam int NXT = (i + 1) % N;
    logic [CW-1:0] waitc;

    // Successor of the last winner ranks highest at the next edge.
    assert_successor_first_R6: assert property (@(posedge clk) disable iff (rst)
      gnt[i] |=> (req[NXT] -> gnt[NXT]));

    always_ff @(posedge clk) begin
      if (rst || !req[i] || gnt[i]) waitc <= '0;
      else                          waitc <= waitc + CW'(1);
    end

    // Prior ungranted cycles of a held request stay below N-1.
    assert_no_starvation_R8: assert property (@(posedge clk) disable iff (rst)
      (req[i] && !gnt[i]) |-> (waitc < CW'(N - 1)));
  end
endmodule

bind rr_arbiter_loopfree rr_arbiter_loopfree_chk #(.N(N)) u_chk (
  .clk (clk),
  .rst (rst),
  .req (req),
  .gnt (gnt)
);

// File: tb/tb_rr_arbiter_loopfree.sv
`timescale 1ns/1ps
module tb_rr_arbiter_loopfree;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req = '0;
  logic [N-1:0] gnt;

  int checks = 0;
  int fails  = 0;
  int mptr   = 0;
  int waits [N];
  bit done   = 0;

  always #2.5 clk = ~clk;

  rr_arbiter_loopfree #(.N(N)) dut (.clk(clk), .rst(rst), .req(req), .gnt(gnt));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model_gnt(input logic [N-1:0] r, input int p);
    for (int k = 0; k < N; k++) begin
      int idx = (p + k) % N;
      if (r[idx]) return N'(1) << idx;
    end
    return '0;
  endfunction

  // Drive one cycle, compare with the model, then advance the model.
  task automatic step(input logic [N-1:0] v, input string tag);
    logic [N-1:0] exp;
    @(negedge clk);
    req = v;
    #1;
    exp = model_gnt(v, mptr);
    check(gnt == exp, (v == '0) ? "R3" : tag, int'(gnt), int'(exp));
    check($onehot0(gnt), "R2", int'(gnt), int'(exp));
    check((gnt & ~v) == '0, "R4", int'(gnt), int'(v));
    for (int i = 0; i < N; i++) begin
      if (v[i] && !gnt[i]) waits[i]++;
      else                 waits[i] = 0;
      check(waits[i] < N, "R8", waits[i], N - 1);
    end
    if (rst) mptr = 0;
    else begin
      for (int i = 0; i < N; i++) if (exp[i]) mptr = (i + 1) % N;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    for (int i = 0; i < N; i++) waits[i] = 0;
    rst = 1'b1;
    step('0, "R1");
    step('0, "R1");
    @(negedge clk); rst = 1'b0;
    mptr = 0;
    // R1: first grant after reset goes to A
    step(4'b1111, "R1");
    // R6: full rotation with all requesting, including the D to A wrap
    for (int k = 0; k < 8; k++) step(4'b1111, "R6");
    // R7: grant A, then idle cycles, then all request: B must win
    step(4'b0001, "R5");
    step(4'b0000, "R7");
    step(4'b0000, "R7");
    step(4'b1111, "R7");
    // R5: every pattern from every pointer value
    for (int p = 0; p < N; p++) begin
      for (int v = 1; v < (1 << N); v++) begin
        step(N'(1) << ((p + N - 1) % N), "R6");
        step(N'(v), "R5");
      end
    end
    // R8: one requester held while others contend
    for (int k = 0; k < 12; k++) step(4'b0100 | N'(k % 16), "R8");
    // Pseudo-random patterns with idle gaps
    lfsr = 8'h5a;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[3:0], "R5");
    end
    // R1: reset mid-run returns the pointer to A
    step(4'b0001, "R5");
    @(negedge clk); rst = 1'b1;
    step(4'b0000, "R1");
    @(negedge clk); rst = 1'b0;
    step(4'b1111, "R1");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule